// File: doc/BRIEF.md
# Strap-configurable management CPU bus slave

This block is a synchronous slave port. An external management processor uses it to read and write 16-bit registers inside the chip, which are addressed by an 11-bit word address. On the processor side it sees an address bus, a data bus that is split into an input, an output and an output enable, an active-low address strobe, an active-low chip select, a read/write control line and an active-low ready. On the chip side it issues single-clock write and read strobes to a register port and waits for a read response. It also drives one interrupt line, and a configuration bit sets the level of that line.

Five strap inputs are sampled on every clock while reset is held. The value present at the last reset clock is kept until the next reset. After reset the strap pins may carry unrelated data. The five straps select four things. Bit 0 selects 1X or 2X clocking: in 2X mode protocol state moves only on every second clock, and the first clock after reset is a non-advancing one. Bit 1 selects byte swapping between the bus and the register port. Bit 2 selects the polarity of the read/write line. Bit 4 selects whether ready coincides with the read data or comes one bus clock ahead of it. Bit 3 has no effect.

The control state machine has eight states. IDLE waits for a strobe. WR_STB issues the write. WR_ACK presents ready for a write. RD_REQ issues the read. RD_WAIT waits for the response. RDY_DATA presents ready together with the data. RDY_EARLY presents ready without data. DATA_LATE presents the data after an early ready. Every transition happens only on an advancing clock. The transitions are:
- IDLE to WR_STB or RD_REQ on a strobe.
- WR_STB to WR_ACK to IDLE.
- RD_REQ to RD_WAIT.
- RD_WAIT to RDY_DATA or RDY_EARLY once a response has been seen.
- RDY_DATA to IDLE.
- RDY_EARLY to DATA_LATE to IDLE.

Top module: `mgmt_bus_slave`

## Requirements
- R1: On each clock with rst_n low the straps are captured. The last captured value governs all behaviour until the next reset, and later changes on strap_i have no effect.
- R2: With strap bit 0 = 1, protocol state advances only on the second, fourth, … clock after reset ends. With bit 0 = 0 it advances on every clock.
- R3: With strap bit 1 = 1, bits 15:8 and 7:0 are exchanged in both directions: bus data to reg_wdata, and reg_rsp_data to bus_data_o. With bit 1 = 0 the bytes pass unchanged.
- R4: With strap bit 2 = 0, bus_rw = 1 means read and 0 means write. With bit 2 = 1 the meanings are reversed.
- R5: Strap bit 3 has no effect on any output.
- R6: A cycle starts in IDLE on an advancing clock where bus_as_n = 0 and bus_cs_n = 0. The address and the write data are captured on that clock.
- R7: A write gives one reg_wr pulse lasting one clock, with the captured address and data, on the next advancing clock. On the advancing clock after that, ready is low for one bus clock, and then the block returns to IDLE.
- R8: A read gives one reg_rd pulse lasting one clock, with the captured address. The block then waits for reg_rsp_valid, which may be a single-clock pulse, and keeps reg_rsp_data from that clock.
- R9: With strap bit 4 = 1, the first advancing clock at or after the response starts one bus clock in which ready is low and the read data is on the bus.
- R10: With strap bit 4 = 0, ready is low for one bus clock while bus_data_o is zero. The read data then follows for one bus clock with ready high.
- R11: bus_data_oe is high only during the ready and data phases of a read. Whenever bus_data_oe is low, bus_data_o is zero.
- R12: A strobe seen while a cycle is outstanding produces no register access and does not change the cycle in progress.
- R13: irq_o is a registered copy of irq_src when irq_pol = 1, and of its inverse when irq_pol = 0. During reset irq_o sits at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low; straps sampled while low |
| strap_i | input | 5 | Configuration straps |
| bus_addr_i | input | 11 | Processor word address |
| bus_data_i | input | 16 | Processor write data |
| bus_data_o | output | 16 | Read data toward the processor |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rw | input | 1 | Read/write control, polarity from strap bit 2 |
| bus_rdy_n | output | 1 | Ready, active low |
| reg_wr | output | 1 | Internal write strobe |
| reg_rd | output | 1 | Internal read request |
| reg_addr | output | 11 | Internal register address |
| reg_wdata | output | 16 | Internal write data |
| reg_rsp_valid | input | 1 | Internal read response valid |
| reg_rsp_data | input | 16 | Internal read response data |
| irq_src | input | 1 | Internal interrupt request |
| irq_pol | input | 1 | Interrupt level select, 1 = active high |
| irq_o | output | 1 | Interrupt output |

## Verification
All outputs other than irq_o are decoded from the state register without further registers. A result therefore shows up in the clock that follows the advancing edge that caused it: reg_wr or reg_rd one bus clock after the strobe is accepted, and ready one bus clock after that, or one bus clock after the response. irq_o follows its inputs after exactly one clock. The bench runs a behavioural model that takes inputs on the rising edge. On each falling edge it compares every output with the model, so each result is checked in the clock where it is due and in no other.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int ADDR_W_DEF = 11;
    localparam int DATA_W_DEF = 16;

    // Field order follows strap bit positions: bit 0 is the LSB.
    typedef struct packed {
        logic rdy_with_data; // bit 4
        logic width_sel;     // bit 3, no effect
        logic rw_high_write; // bit 2
        logic byte_swap;     // bit 1
        logic clk_div2;      // bit 0
    } strap_cfg_t;

    localparam int STRAP_W = $bits(strap_cfg_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_STB,
        ST_WR_ACK,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_RDY_DATA,
        ST_RDY_EARLY,
        ST_DATA_LATE
    } bus_state_t;

endpackage

// File: rtl/mbs_strap_latch.sv
module mbs_strap_latch
    import mbs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STRAP_W-1:0]  strap_i,
    output strap_cfg_t          cfg_o,
    output logic                adv_o
);

    strap_cfg_t cfg_q;
    logic       phase_q;

    // Captured on every reset clock; the last one wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= strap_cfg_t'(strap_i);
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign cfg_o = cfg_q;
    assign adv_o = !cfg_q.clk_div2 || phase_q;

endmodule

// File: rtl/mbs_byte_lane.sv
module mbs_byte_lane #(
    parameter int DATA_W = 16
) (
    input  logic              swap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int LANES = DATA_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[8*i +: 8] = swap_en ? din[8*(LANES-1-i) +: 8] : din[8*i +: 8];
    end

endmodule

// File: rtl/mbs_bus_fsm.sv
module mbs_bus_fsm
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              rw_high_write,
    input  logic              rdy_with_data,
    input  logic              as_n,
    input  logic              cs_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              req_wr,
    output logic              req_rd,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive,
    output logic              oe,
    output logic              rdy_n
);

    bus_state_t        state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              got_q;
    logic              start;
    logic              is_read;

    assign start   = !as_n && !cs_n;
    assign is_read = rw ^ rw_high_write;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = is_read ? ST_RD_REQ : ST_WR_STB;
            ST_WR_STB:    nxt = ST_WR_ACK;
            ST_WR_ACK:    nxt = ST_IDLE;
            ST_RD_REQ:    nxt = ST_RD_WAIT;
            ST_RD_WAIT:   if (got_q || rsp_valid)
                              nxt = rdy_with_data ? ST_RDY_DATA : ST_RDY_EARLY;
            ST_RDY_DATA:  nxt = ST_IDLE;
            ST_RDY_EARLY: nxt = ST_DATA_LATE;
            ST_DATA_LATE: nxt = ST_IDLE;
        endcase
    end

    // State register and captured cycle context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            got_q   <= 1'b0;
        end else begin
            if (state == ST_RD_WAIT && rsp_valid && !got_q) begin
                rdata_q <= rsp_data;
                got_q   <= 1'b1;
            end
            if (adv) begin
                state <= nxt;
                if (state == ST_IDLE && start) begin
                    addr_q  <= addr_i;
                    wdata_q <= wdata_i;
                    got_q   <= 1'b0;
                end
            end
        end
    end

    // Outputs decoded from state.
    always_comb begin
        req_wr      = (state == ST_WR_STB) && adv;
        req_rd      = (state == ST_RD_REQ) && adv;
        req_addr    = addr_q;
        req_wdata   = wdata_q;
        rdata       = rdata_q;
        rdy_n       = !(state inside {ST_WR_ACK, ST_RDY_DATA, ST_RDY_EARLY});
        oe          = state inside {ST_RDY_DATA, ST_RDY_EARLY, ST_DATA_LATE};
        rdata_drive = state inside {ST_RDY_DATA, ST_DATA_LATE};
    end

endmodule

// File: rtl/mbs_irq_out.sv
module mbs_irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_src,
    input  logic irq_pol,
    output logic irq_o
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= !irq_pol;
        else        irq_q <= irq_src ^ !irq_pol;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/mgmt_bus_slave.sv
module mgmt_bus_slave
    import mbs_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        strap_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_data_i,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              bus_data_oe,
    input  logic              bus_as_n,
    input  logic              bus_cs_n,
    input  logic              bus_rw,
    output logic              bus_rdy_n,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rsp_valid,
    input  logic [DATA_W-1:0] reg_rsp_data,
    input  logic              irq_src,
    input  logic              irq_pol,
    output logic              irq_o
);

    strap_cfg_t        cfg;
    logic              adv;
    logic [DATA_W-1:0] wdata_sw;
    logic [DATA_W-1:0] rdata_raw;
    logic [DATA_W-1:0] rdata_sw;
    logic              rdata_drive;

    mbs_strap_latch u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_i),
        .cfg_o   (cfg),
        .adv_o   (adv)
    );

    mbs_byte_lane #(.DATA_W(DATA_W)) u_wr_lane (
        .swap_en (cfg.byte_swap),
        .din     (bus_data_i),
        .dout    (wdata_sw)
    );

    mbs_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .adv           (adv),
        .rw_high_write (cfg.rw_high_write),
        .rdy_with_data (cfg.rdy_with_data),
        .as_n          (bus_as_n),
        .cs_n          (bus_cs_n),
        .rw            (bus_rw),
        .addr_i        (bus_addr_i),
        .wdata_i       (wdata_sw),
        .rsp_valid     (reg_rsp_valid),
        .rsp_data      (reg_rsp_data),
        .req_wr        (reg_wr),
        .req_rd        (reg_rd),
        .req_addr      (reg_addr),
        .req_wdata     (reg_wdata),
        .rdata         (rdata_raw),
        .rdata_drive   (rdata_drive),
        .oe            (bus_data_oe),
        .rdy_n         (bus_rdy_n)
    );

    mbs_byte_lane #(.DATA_W(DATA_W)) u_rd_lane (
        .swap_en (cfg.byte_swap),
        .din     (rdata_raw),
        .dout    (rdata_sw)
    );

    assign bus_data_o = rdata_drive ? rdata_sw : '0;

    mbs_irq_out u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_src (irq_src),
        .irq_pol (irq_pol),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker
    import mbs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input strap_cfg_t        cfg,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              bus_rdy_n,
    input logic              bus_data_oe,
    input logic [DATA_W-1:0] bus_data_o,
    input logic              irq_src,
    input logic              irq_pol,
    input logic              irq_o
);

    assert_cfg_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(cfg));

    assert_wr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_rd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    assert_rdy_one_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.clk_div2 && !bus_rdy_n) |=> bus_rdy_n);

    assert_idle_bus_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_data_oe |-> (bus_data_o == '0));

    assert_no_dual_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    assert_irq_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == ($past(irq_src) ^ !$past(irq_pol))));

endmodule

bind mgmt_bus_slave mbs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .bus_rdy_n   (bus_rdy_n),
    .bus_data_oe (bus_data_oe),
    .bus_data_o  (bus_data_o),
    .irq_src     (irq_src),
    .irq_pol     (irq_pol),
    .irq_o       (irq_o)
);

// File: tb/sim_mgmt_bus_slave.sv
`timescale 1ns/1ps
module sim_mgmt_bus_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_i = '0;
    logic [10:0] bus_addr_i = '0;
    logic [15:0] bus_data_i = '0;
    logic [15:0] bus_data_o;
    logic        bus_data_oe;
    logic        bus_as_n = 1'b1;
    logic        bus_cs_n = 1'b1;
    logic        bus_rw = 1'b0;
    logic        bus_rdy_n;
    logic        reg_wr, reg_rd;
    logic [10:0] reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_rsp_valid = 1'b0;
    logic [15:0] reg_rsp_data = '0;
    logic        irq_src = 1'b0;
    logic        irq_pol = 1'b1;
    logic        irq_o;

    always #4 clk = ~clk;

    mgmt_bus_slave u0 (.*);

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_tag = "R1";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s/%s act=%h exp=%h t=%0t", cur_tag, tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] swp(input bit en, input logic [15:0] v);
        return en ? {v[7:0], v[15:8]} : v;
    endfunction

    // Behavioural reference: 0 idle,1 write strobe,2 write ack,3 read req,
    // 4 wait,5 ready+data,6 early ready,7 late data.
    int          mst = 0;
    bit          ph = 0;
    logic [4:0]  mcfg = '0;
    logic [10:0] maddr = '0;
    logic [15:0] mwd = '0, mrd = '0;
    bit          mgot = 0;
    bit          mirq = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mcfg = strap_i; ph = 0; mst = 0; mgot = 0;
            maddr = '0; mwd = '0; mrd = '0; mirq = !irq_pol;
        end else begin
            bit tick;
            tick = !mcfg[0] || ph;
            mirq = irq_src ^ !irq_pol;
            if (mst == 4 && reg_rsp_valid && !mgot) begin mrd = reg_rsp_data; mgot = 1; end
            if (tick) begin
                case (mst)
                    0: if (!bus_as_n && !bus_cs_n) begin
                           maddr = bus_addr_i; mwd = swp(mcfg[1], bus_data_i); mgot = 0;
                           mst = (bus_rw ^ mcfg[2]) ? 3 : 1;
                       end
                    1: mst = 2;
                    3: mst = 4;
                    4: if (mgot) mst = mcfg[4] ? 5 : 6;
                    6: mst = 7;
                    default: mst = 0;
                endcase
            end
            ph = !ph;
        end
    end

    // Register responder and per-clock comparison.
    logic [15:0] mem [16];
    int          rsp_lat = 1;
    int          pend = 0;
    logic [3:0]  paddr = '0;
    int          wr_cnt = 0;

    initial for (int i = 0; i < 16; i++) mem[i] = '0;

    always @(negedge clk) begin
        if (cmp_on) begin
            bit et;
            et = !mcfg[0] || ph;
            chk("R9 rdy", {31'd0, bus_rdy_n}, {31'd0, !(mst == 2 || mst == 5 || mst == 6)});
            chk("R11 oe", {31'd0, bus_data_oe}, {31'd0, (mst >= 5)});
            chk("R3 rdata", {16'd0, bus_data_o},
                {16'd0, (mst == 5 || mst == 7) ? swp(mcfg[1], mrd) : 16'h0});
            chk("R7 wr", {31'd0, reg_wr}, {31'd0, (mst == 1 && et)});
            chk("R8 rd", {31'd0, reg_rd}, {31'd0, (mst == 3 && et)});
            if (reg_wr || reg_rd) chk("R6 addr", {21'd0, reg_addr}, {21'd0, maddr});
            if (reg_wr) chk("R3 wdata", {16'd0, reg_wdata}, {16'd0, mwd});
            chk("R13 irq", {31'd0, irq_o}, {31'd0, mirq});
        end
        reg_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin reg_rsp_valid = 1'b1; reg_rsp_data = mem[paddr]; end
        end
        if (reg_wr) begin mem[reg_addr[3:0]] = reg_wdata; wr_cnt++; end
        if (reg_rd) begin pend = rsp_lat; paddr = reg_addr[3:0]; end
    end

    logic [4:0] cur_strap = '0;

    task automatic do_reset(input logic [4:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap_i = s; cur_strap = s;
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        rst_n = 1'b1;
        strap_i = ~s; // pins reused after reset (R1)
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_cycle(input bit is_rd, input logic [10:0] a, input logic [15:0] d,
                             output logic [15:0] rv);
        int hold;
        bit seen;
        hold = cur_strap[0] ? 2 : 1;
        rv = '0;
        seen = 0;
        @(negedge clk);
        bus_as_n = 0; bus_cs_n = 0; bus_rw = is_rd ^ cur_strap[2];
        bus_addr_i = a; bus_data_i = d;
        repeat (hold) @(negedge clk);
        bus_as_n = 1; bus_cs_n = 1;
        for (int i = 0; i < 200 && !seen; i++) begin
            if (bus_data_oe) rv = bus_data_o;
            if (!bus_rdy_n) seen = 1; else @(negedge clk);
        end
        chk("ready seen", {31'd0, seen}, 32'd1);
        repeat (6) begin
            if (bus_data_oe) rv = bus_data_o;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [15:0] rv;
        // Baseline: 1X, straight bytes, high=read, ready with data.
        do_reset(5'b10000);
        cur_tag = "R1";
        chk("R1 rdy idle", {31'd0, bus_rdy_n}, 32'd1);
        chk("R1 oe idle", {31'd0, bus_data_oe}, 32'd0);
        cur_tag = "R7";
        bus_cycle(0, 11'h003, 16'h1234, rv);
        chk("R7 mem", {16'd0, mem[3]}, 32'h1234);
        cur_tag = "R9";
        bus_cycle(1, 11'h003, 16'h0000, rv);
        chk("R9 read", {16'd0, rv}, 32'h1234);
        cur_tag = "R13";
        irq_src = 1; repeat (3) @(negedge clk);
        chk("R13 hi", {31'd0, irq_o}, 32'd1);
        irq_pol = 0; repeat (2) @(negedge clk);
        chk("R13 lo", {31'd0, irq_o}, 32'd0);
        irq_src = 0; irq_pol = 1; repeat (2) @(negedge clk);

        // Swap, early ready; strap pins toggled after reset.
        do_reset(5'b00010);
        cur_tag = "R1";
        bus_cycle(0, 11'h005, 16'hABCD, rv);
        chk("R3 swapped write", {16'd0, mem[5]}, 32'hCDAB);
        cur_tag = "R10";
        rsp_lat = 3;
        bus_cycle(1, 11'h005, 16'h0000, rv);
        chk("R10 read back", {16'd0, rv}, 32'hABCD);
        rsp_lat = 1;

        // Inverted rw, width strap set, early ready.
        do_reset(5'b01100);
        cur_tag = "R4";
        bus_cycle(0, 11'h007, 16'h5A0F, rv);
        chk("R4 write level", {16'd0, mem[7]}, 32'h5A0F);
        cur_tag = "R5";
        bus_cycle(1, 11'h007, 16'h0000, rv);
        chk("R5 read", {16'd0, rv}, 32'h5A0F);

        // 2X clocking with swap and ready with data.
        do_reset(5'b10011);
        cur_tag = "R2";
        bus_cycle(0, 11'h00A, 16'h2468, rv);
        chk("R2 write", {16'd0, mem[10]}, 32'h6824);
        rsp_lat = 3;
        bus_cycle(1, 11'h00A, 16'h0000, rv);
        chk("R2 read", {16'd0, rv}, 32'h2468);
        rsp_lat = 1;

        // Strobe during outstanding read.
        do_reset(5'b10000);
        cur_tag = "R12";
        rsp_lat = 6;
        begin
            int wc;
            wc = wr_cnt;
            @(negedge clk);
            bus_as_n = 0; bus_cs_n = 0; bus_rw = 1; bus_addr_i = 11'h003;
            @(negedge clk);
            bus_as_n = 1; bus_cs_n = 1;
            repeat (2) @(negedge clk);
            bus_as_n = 0; bus_cs_n = 0; bus_rw = 0; bus_addr_i = 11'h009; bus_data_i = 16'h5555;
            @(negedge clk);
            bus_as_n = 1; bus_cs_n = 1;
            repeat (20) @(negedge clk);
            chk("R12 no write", wr_cnt - wc, 32'd0);
            chk("R12 mem kept", {16'd0, mem[9]}, 32'h0000);
        end
        rsp_lat = 1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule